// File: doc/BRIEF.md
# Calendar Time Counter

This block keeps the wall-clock calendar state of a real-time clock: seconds, minutes, hours, day of month, month, two-digit year and century. Each field is one byte. A one-cycle advance strobe from an external update controller moves the whole calendar forward by exactly one second. Each field that passes its top value wraps to its bottom value and carries into the next field, from seconds all the way to the century.

Two mode inputs choose how the bytes are encoded. One picks packed BCD or plain binary. The other picks a 24-hour clock, or a 12-hour clock whose hour byte carries a PM flag in its top bit. The host reaches the fields through a byte write port and a combinational read port, both indexed by a field address. A host write stores its byte exactly as given and takes priority over an advance in the same cycle. Address decoding of a bus, alarm comparison and the timing of the update strobe are left to neighbouring blocks.

Top module: `calt_counter`

## Requirements
- R1: After a synchronous active-low reset, fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and century 0x00.
- R2: With no strobe and no write, every field keeps its value.
- R3: A strobe adds one second in the selected encoding: with `bin_mode` low (packed BCD, tens in bits 7:4, units in bits 3:0) seconds 0x09 become 0x10; with `bin_mode` high, 0x09 becomes 0x0A.
- R4: Seconds and minutes wrap from 59 to 0 and carry into the next field, so 09:59:59 becomes 10:00:00.
- R5: With `h24_mode` high, hour 23 at 59:59 wraps to 00:00:00 and the day advances.
- R6: With `h24_mode` low, hour bit 7 is the PM flag and bits 6:0 hold 1 to 12; 11:59:59 AM becomes 12:00:00 PM (BCD 0x11 to 0x92, binary 0x0B to 0x8C) and the day does not change.
- R7: In 12-hour mode, 11:59:59 PM becomes 12:00:00 AM (BCD 0x91 to 0x12, binary 0x8B to 0x0C) and the day advances.
- R8: In 12-hour mode, hour 12 at 59:59 becomes 1 with the PM flag unchanged (BCD 0x92 to 0x81 and 0x12 to 0x01, binary 0x8C to 0x81).
- R9: The day wraps to 1 after the last day of its month: 30 for months 4, 6, 9 and 11; 31 for the other months; 28 or 29 for month 2. The month then advances.
- R10: February has 29 days when the year is a multiple of 4, except that year 00 is a leap year only when the century is a multiple of 4 (so 2000 and 2024 are leap years and 1900 is not).
- R11: Month 12 wraps to 1 and carries into the year; year 99 wraps to 0 and carries into the century.
- R12: Field addresses are 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year and 6 century. A write stores its byte unaltered (year 0x80 with century 0x20 reads back as written). Address 7 reads 0x00, and a write to it changes nothing.
- R13: A write in the same cycle as a strobe sets the addressed field to the written byte. All other fields advance as they would without the write, and a carry into the written field is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe: advance by one second |
| bin_mode | input | 1 | 1: binary fields, 0: packed BCD fields |
| h24_mode | input | 1 | 1: 24-hour clock, 0: 12-hour clock with PM flag in hour bit 7 |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | ADDR_W | Field address of the write |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | ADDR_W | Field address of the read |
| rd_data | output | 8 | Byte stored at rd_addr (combinational) |

## Verification
A host write and a one-second advance can land in the same clock edge. Depending on the address, the write can hit the field that is itself advancing, or a field that is about to receive a carry. The bench raises the strobe and the write enable together. It does this once with the write aimed at an untouched higher field, and once with seconds at 59 so that the write replaces the minute that would have taken the carry. It then expects the written byte in the addressed field and the normal advance everywhere else.

// File: rtl/calt_pkg.sv
// Package: shared byte type, field indices and the encode/decode helpers
// used by every stage of the calendar counter.
// Assumes decoded field values never exceed 99, so they fit in 7 bits.
package calt_pkg;

    localparam int BYTE_W     = 8;
    localparam int VAL_W      = 7;
    localparam int NUM_FIELDS = 7;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [VAL_W-1:0]  val_t;

    // Field order is also the carry order, lowest first.
    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_DAY  = 3'd3,
        F_MON  = 3'd4,
        F_YEAR = 3'd5,
        F_CENT = 3'd6
    } field_e;

    // Turn a stored byte into its numeric value.
    function automatic val_t decode(input byte_t raw, input logic bin);
        if (bin) decode = raw[VAL_W-1:0];
        else     decode = VAL_W'(raw[7:4] * 10 + raw[3:0]);
    endfunction

    // Turn a numeric value back into a stored byte.
    function automatic byte_t encode(input val_t v, input logic bin);
        if (bin) encode = {1'b0, v};
        else     encode = {4'(v / VAL_W'(10)), 4'(v % VAL_W'(10))};
    endfunction

    // Value a field returns to after it wraps.
    function automatic val_t field_lo(input int idx);
        if (idx == int'(F_DAY) || idx == int'(F_MON)) field_lo = VAL_W'(1);
        else                                         field_lo = VAL_W'(0);
    endfunction

    // Top value of each fixed-range field (the day limit is computed elsewhere).
    function automatic val_t field_hi(input int idx);
        case (idx)
            int'(F_SEC), int'(F_MIN): field_hi = VAL_W'(59);
            int'(F_MON):              field_hi = VAL_W'(12);
            default:                  field_hi = VAL_W'(99);
        endcase
    endfunction

    // Reset byte of each field; the same in both encodings.
    function automatic byte_t reset_val(input int idx);
        if (idx == int'(F_DAY) || idx == int'(F_MON)) reset_val = BYTE_W'(1);
        else                                         reset_val = '0;
    endfunction

endpackage

// File: rtl/calt_month_len.sv
// Module: last day of the current month, with the leap rule taken from
// the two-digit year and the century.
// Assumes inputs are decoded binary values; out-of-range months give 31.
module calt_month_len
    import calt_pkg::*;
(
    input  val_t month,
    input  val_t year,
    input  val_t cent,
    output val_t last_day
);

    logic leap;

    // Leap year: year divisible by 4; year 00 also needs a century divisible by 4.
    always_comb begin
        leap = (year[1:0] == 2'b00) && ((year != '0) || (cent[1:0] == 2'b00));
    end

    // Month length lookup.
    always_comb begin
        case (month)
            VAL_W'(2):                                    last_day = leap ? VAL_W'(29) : VAL_W'(28);
            VAL_W'(4), VAL_W'(6), VAL_W'(9), VAL_W'(11): last_day = VAL_W'(30);
            default:                                      last_day = VAL_W'(31);
        endcase
    end

endmodule

// File: rtl/calt_field_step.sv
// Module: one plain wrapping field. When a carry arrives it adds one, or wraps
// to lo after hi and passes the carry upward.
// Assumes the stored value is already inside lo..hi; values above hi wrap too.
module calt_field_step
    import calt_pkg::*;
(
    input  byte_t raw,
    input  logic  bin,
    input  logic  carry_in,
    input  val_t  lo,
    input  val_t  hi,
    output byte_t nxt,
    output logic  carry_out
);

    val_t v;

    // Next byte and carry for this field.
    always_comb begin
        v         = decode(raw, bin);
        nxt       = raw;
        carry_out = 1'b0;
        if (carry_in) begin
            if (v >= hi) begin
                nxt       = encode(lo, bin);
                carry_out = 1'b1;
            end else begin
                nxt = encode(v + VAL_W'(1), bin);
            end
        end
    end

endmodule

// File: rtl/calt_hour_step.sv
// Module: hour field with 24-hour and 12-hour (PM flag in bit 7) rules.
// Assumes in 12-hour mode that bits 6:0 hold 1..12; a zero there counts up to 1.
module calt_hour_step
    import calt_pkg::*;
(
    input  byte_t hr_raw,
    input  logic  bin,
    input  logic  h24,
    input  logic  carry_in,
    output byte_t hr_next,
    output logic  carry_out
);

    val_t  v24;
    val_t  v12;
    logic  pm;
    byte_t enc12;
    byte_t enc1;
    byte_t enc_inc;

    // Decode the hour both ways and prepare the candidate bytes.
    always_comb begin
        v24     = decode(hr_raw, bin);
        v12     = decode({1'b0, hr_raw[6:0]}, bin);
        pm      = hr_raw[7];
        enc12   = encode(VAL_W'(12), bin);
        enc1    = encode(VAL_W'(1), bin);
        enc_inc = encode(v12 + VAL_W'(1), bin);
    end

    // Pick the next hour byte and whether the day must advance.
    always_comb begin
        hr_next   = hr_raw;
        carry_out = 1'b0;
        if (carry_in) begin
            if (h24) begin
                if (v24 >= VAL_W'(23)) begin
                    hr_next   = '0;
                    carry_out = 1'b1;
                end else begin
                    hr_next = encode(v24 + VAL_W'(1), bin);
                end
            end else if (v12 == VAL_W'(11)) begin
                hr_next   = {~pm, enc12[6:0]};
                carry_out = pm;
            end else if (v12 >= VAL_W'(12)) begin
                hr_next = {pm, enc1[6:0]};
            end else begin
                hr_next = {pm, enc_inc[6:0]};
            end
        end
    end

endmodule

// File: rtl/calt_counter.sv
// Module: calendar time counter top. It holds seven byte fields, advances them
// by one second per strobe with a carry chain, and gives host write/read access.
// Assumes tick is a single-cycle strobe; a host write beats the advance for its field.
module calt_counter
    import calt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bin_mode,
    input  logic              h24_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [NUM_FIELDS-1:0][BYTE_W-1:0] regs;
    logic [NUM_FIELDS-1:0][BYTE_W-1:0] nxt;
    logic [NUM_FIELDS:0]               carry;
    val_t                              last_day;

    assign carry[0] = tick;

    // Month length from the current month, year and century.
    calt_month_len u_mlen (
        .month    (decode(regs[F_MON],  bin_mode)),
        .year     (decode(regs[F_YEAR], bin_mode)),
        .cent     (decode(regs[F_CENT], bin_mode)),
        .last_day (last_day)
    );

    // Carry chain: one stage per field, with the hour using its own rules.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        if (i == int'(F_HOUR)) begin : g_hr
            calt_hour_step u_hr (
                .hr_raw    (regs[i]),
                .bin       (bin_mode),
                .h24       (h24_mode),
                .carry_in  (carry[i]),
                .hr_next   (nxt[i]),
                .carry_out (carry[i+1])
            );
        end else begin : g_plain
            val_t hi_lim;
            if (i == int'(F_DAY)) begin : g_dim
                assign hi_lim = last_day;
            end else begin : g_fix
                assign hi_lim = field_hi(i);
            end
            calt_field_step u_fs (
                .raw       (regs[i]),
                .bin       (bin_mode),
                .carry_in  (carry[i]),
                .lo        (field_lo(i)),
                .hi        (hi_lim),
                .nxt       (nxt[i]),
                .carry_out (carry[i+1])
            );
        end
    end

    // Field storage: reset, host write first, otherwise the advanced value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_FIELDS; i++) regs[i] <= reset_val(i);
        end else begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (wr_en && (wr_addr == ADDR_W'(i))) regs[i] <= wr_data;
                else                                  regs[i] <= nxt[i];
            end
        end
    end

    // Read mux; unused addresses return zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
        end
    end

    // Decoded views used by the checks below.
    val_t sec_v, min_v, hr24_v, hr12_v;
    always_comb begin
        sec_v  = decode(regs[F_SEC], bin_mode);
        min_v  = decode(regs[F_MIN], bin_mode);
        hr24_v = decode(regs[F_HOUR], bin_mode);
        hr12_v = decode({1'b0, regs[F_HOUR][6:0]}, bin_mode);
    end

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(regs));

    a_r3_bin_sec_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && bin_mode && regs[F_SEC] < 8'd59)
        |=> regs[F_SEC] == $past(regs[F_SEC]) + 8'd1);

    a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && sec_v == VAL_W'(59)) |=> regs[F_SEC] == '0);

    a_r5_midnight_24h: assert property (@(posedge clk) disable iff (!rst_n)
        (h24_mode && carry[F_HOUR] && !wr_en && hr24_v == VAL_W'(23))
        |=> regs[F_HOUR] == '0);

    a_r6_noon_sets_pm: assert property (@(posedge clk) disable iff (!rst_n)
        (!h24_mode && carry[F_HOUR] && !wr_en && hr12_v == VAL_W'(11) && !regs[F_HOUR][7])
        |=> regs[F_HOUR][7]);

    a_r11_cent_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (carry[NUM_FIELDS] && !wr_en) |=> regs[F_CENT] == '0);

    a_r13_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(F_SEC)) |=> regs[F_SEC] == $past(wr_data));

    // Minutes must not change without a carry out of seconds or a write.
    a_r4_min_needs_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry[F_MIN] && !wr_en) |=> regs[F_MIN] == $past(regs[F_MIN]));

endmodule

// File: tb/sim_calt_counter.sv
// Scoreboard bench: driver tasks queue expected field values, and a monitor
// pops each one, selects it on the read port and compares.
module sim_calt_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bin_mode = 1'b0;
    logic       h24_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] q_addr[$];
    logic [7:0] q_val[$];
    string      q_tag[$];

    always #2ns clk = ~clk;

    calt_counter #(.ADDR_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bin_mode(bin_mode),
        .h24_mode(h24_mode), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Monitor: pops one expected item per cycle and compares the read port.
    initial begin
        forever begin
            @(negedge clk);
            if (q_addr.size() != 0) begin
                logic [2:0] a;
                logic [7:0] v;
                string t;
                a = q_addr.pop_front();
                v = q_val.pop_front();
                t = q_tag.pop_front();
                rd_addr = a;
                #1ns;
                checks++;
                if (rd_data !== v) begin
                    errors++;
                    $display("FAIL %s: field %0d actual %02h expected %02h", t, a, rd_data, v);
                end
            end
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] v, input string t);
        q_addr.push_back(a);
        q_val.push_back(v);
        q_tag.push_back(t);
    endtask

    task automatic drain();
        while (q_addr.size() != 0) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic step_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic set_dt(input logic [7:0] h, mi, s, d, mo, y, c);
        wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
        wr(3'd3, d); wr(3'd4, mo); wr(3'd5, y); wr(3'd6, c);
    endtask

    task automatic expect_dt(input logic [7:0] h, mi, s, d, mo, y, c, input string t);
        expect_reg(3'd2, h, t); expect_reg(3'd1, mi, t); expect_reg(3'd0, s, t);
        expect_reg(3'd3, d, t); expect_reg(3'd4, mo, t); expect_reg(3'd5, y, t);
        expect_reg(3'd6, c, t);
        drain();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver: stimulus and expected values.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_dt(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, "R1");

        // R2 idle cycles change nothing
        repeat (6) @(negedge clk);
        expect_dt(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, "R2");

        // R3 BCD and binary single-second steps
        wr(3'd0, 8'h09); step();
        expect_reg(3'd0, 8'h10, "R3"); drain();
        bin_mode = 1'b1;
        wr(3'd0, 8'h09); step();
        expect_reg(3'd0, 8'h0A, "R3"); drain();
        bin_mode = 1'b0;

        // R4 second and minute carries in BCD
        set_dt(8'h09, 8'h59, 8'h59, 8'h02, 8'h02, 8'h11, 8'h20); step();
        expect_dt(8'h10, 8'h00, 8'h00, 8'h02, 8'h02, 8'h11, 8'h20, "R4");

        // R5 24-hour midnight wrap
        set_dt(8'h23, 8'h59, 8'h59, 8'h05, 8'h03, 8'h11, 8'h20); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h06, 8'h03, 8'h11, 8'h20, "R5");

        // R6 12-hour 11 AM to 12 PM, BCD then binary
        h24_mode = 1'b0;
        set_dt(8'h11, 8'h59, 8'h59, 8'h05, 8'h03, 8'h11, 8'h20); step();
        expect_dt(8'h92, 8'h00, 8'h00, 8'h05, 8'h03, 8'h11, 8'h20, "R6");
        bin_mode = 1'b1;
        set_dt(8'h0B, 8'h3B, 8'h3B, 8'h05, 8'h03, 8'h0B, 8'h14); step();
        expect_dt(8'h8C, 8'h00, 8'h00, 8'h05, 8'h03, 8'h0B, 8'h14, "R6");

        // R7 12-hour 11 PM to 12 AM with day carry
        set_dt(8'h8B, 8'h3B, 8'h3B, 8'h05, 8'h03, 8'h0B, 8'h14); step();
        expect_dt(8'h0C, 8'h00, 8'h00, 8'h06, 8'h03, 8'h0B, 8'h14, "R7");
        bin_mode = 1'b0;
        set_dt(8'h91, 8'h59, 8'h59, 8'h05, 8'h03, 8'h11, 8'h20); step();
        expect_dt(8'h12, 8'h00, 8'h00, 8'h06, 8'h03, 8'h11, 8'h20, "R7");

        // R8 12 to 1 keeps the PM flag
        set_dt(8'h92, 8'h59, 8'h59, 8'h05, 8'h03, 8'h11, 8'h20); step();
        expect_dt(8'h81, 8'h00, 8'h00, 8'h05, 8'h03, 8'h11, 8'h20, "R8");
        set_dt(8'h12, 8'h59, 8'h59, 8'h05, 8'h03, 8'h11, 8'h20); step();
        expect_dt(8'h01, 8'h00, 8'h00, 8'h05, 8'h03, 8'h11, 8'h20, "R8");
        bin_mode = 1'b1;
        set_dt(8'h8C, 8'h3B, 8'h3B, 8'h05, 8'h03, 8'h0B, 8'h14); step();
        expect_dt(8'h81, 8'h00, 8'h00, 8'h05, 8'h03, 8'h0B, 8'h14, "R8");
        bin_mode = 1'b0;
        h24_mode = 1'b1;

        // R9 month lengths
        set_dt(8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h11, 8'h20); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h11, 8'h20, "R9");
        set_dt(8'h23, 8'h59, 8'h59, 8'h29, 8'h04, 8'h11, 8'h20); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h30, 8'h04, 8'h11, 8'h20, "R9");
        set_dt(8'h23, 8'h59, 8'h59, 8'h31, 8'h01, 8'h11, 8'h20); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h11, 8'h20, "R9");

        // R10 leap rules
        set_dt(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24, 8'h20); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, 8'h20, "R10");
        set_dt(8'h23, 8'h59, 8'h59, 8'h29, 8'h02, 8'h24, 8'h20); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h24, 8'h20, "R10");
        set_dt(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h00, 8'h19); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h00, 8'h19, "R10");
        set_dt(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h00, 8'h20); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h00, 8'h20, "R10");
        set_dt(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h11, 8'h20); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h11, 8'h20, "R10");

        // R11 year end and century carry, BCD then binary
        set_dt(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 8'h19); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h20, "R11");
        set_dt(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h41, 8'h20); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h42, 8'h20, "R11");
        bin_mode = 1'b1;
        set_dt(8'h17, 8'h3B, 8'h3B, 8'h1F, 8'h0C, 8'h63, 8'h13); step();
        expect_dt(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h14, "R11");
        bin_mode = 1'b0;

        // R12 verbatim storage and the unused address
        set_dt(8'h02, 8'h04, 8'h58, 8'h02, 8'h02, 8'h80, 8'h20);
        expect_dt(8'h02, 8'h04, 8'h58, 8'h02, 8'h02, 8'h80, 8'h20, "R12");
        wr(3'd7, 8'h55);
        expect_reg(3'd7, 8'h00, "R12");
        drain();
        expect_dt(8'h02, 8'h04, 8'h58, 8'h02, 8'h02, 8'h80, 8'h20, "R12");

        // R13 write and strobe in the same cycle
        set_dt(8'h05, 8'h10, 8'h30, 8'h02, 8'h02, 8'h11, 8'h20);
        step_write(3'd1, 8'h45);
        expect_dt(8'h05, 8'h45, 8'h31, 8'h02, 8'h02, 8'h11, 8'h20, "R13");
        set_dt(8'h05, 8'h10, 8'h59, 8'h02, 8'h02, 8'h11, 8'h20);
        step_write(3'd1, 8'h12);
        expect_dt(8'h05, 8'h12, 8'h00, 8'h02, 8'h02, 8'h11, 8'h20, "R13");
        set_dt(8'h05, 8'h10, 8'h20, 8'h02, 8'h02, 8'h11, 8'h20);
        step_write(3'd0, 8'h40);
        expect_dt(8'h05, 8'h10, 8'h40, 8'h02, 8'h02, 8'h11, 8'h20, "R13");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule